// File: doc/BRIEF.md
# PWM Output-Enable Commit Controller

This block decides the moment at which software-requested output enables for a small bank of PWM channels reach the PWM generator. Every channel carries two copies of its enable. A requested copy is loaded by a register write. An active copy is the only one the generator sees. A per-channel 2-bit policy field selects when the requested copy is moved into the active copy. The move can happen on the write itself, at the next counter-zero strobe from the generator, or at the first counter-zero strobe after a global update request.

The global update request is a one-cycle pulse from a master control register. It sets a sticky pending flag, which the block reports as a status bit. The flag is consumed by the counter-zero strobe that commits the globally synchronized channels. Register writes, the counter-zero strobe and the request are plain control pins, sampled on the rising clock edge. They have no handshake because the block always accepts them in the cycle they are presented. Counter generation, dead-band, fault logic and bus decode are handled elsewhere.

Top module: `pwm_en_sync`

## Requirements
- R1: With a channel's policy field at 2'b00, a write to the enable register shows on that channel's `en_active` bit in the cycle after the write edge.
- R2: With the policy field at 2'b10, `en_active` keeps its value while `cnt_zero` is low and takes the requested value at the edge where `cnt_zero` is high.
- R3: With the policy field at 2'b11, the requested value is committed only at a `cnt_zero` edge while `glb_pending` is 1. A `cnt_zero` edge with `glb_pending` at 0 leaves `en_active` unchanged.
- R4: The policy encoding 2'b01 behaves exactly like 2'b00.
- R5: A `glb_req` pulse sets `glb_pending` from the next cycle. A `cnt_zero` edge without `glb_req` clears it. When `glb_req` and `cnt_zero` arrive in the same cycle, `glb_pending` is 1 afterwards.
- R6: When an enable write and `cnt_zero` arrive in the same cycle on a channel in a synchronized policy, the newly written value is the one committed.
- R7: After reset, `en_active`, `en_req`, `mode_cfg` and `glb_pending` are all 0, which means every channel uses the immediate policy.
- R8: Channel i's policy field sits at `mode_cfg`/`mode_wdata` bits [2i+1:2i]: channel 3 at 7:6, channel 2 at 5:4, channel 1 at 3:2 and channel 0 at 1:0. Each channel follows only its own field.
- R9: `en_req` returns the last written enable bits. When several writes occur before a synchronized commit, the latest written value is the one committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Write strobe for the requested enable bits |
| en_wdata | input | NUM_CH | Requested enable value, bit i for channel i |
| mode_wr | input | 1 | Write strobe for the policy fields |
| mode_wdata | input | 2*NUM_CH | Packed policy fields |
| cnt_zero | input | 1 | Counter-zero strobe from the PWM generator |
| glb_req | input | 1 | One-cycle global update request |
| en_active | output | NUM_CH | Enables in use by the generator |
| en_req | output | NUM_CH | Readback of the requested enables |
| mode_cfg | output | 2*NUM_CH | Readback of the policy fields |
| glb_pending | output | 1 | Global update requested and not yet consumed |

## Verification
Two situations are the hardest to create from the ports. The first is a globally synchronized channel that meets a counter-zero strobe with no pending request. The second is a counter-zero strobe that coincides with a request or with a fresh write. Both require the pending flag and the requested value to be set up in exact cycle order. The stimulus table sets all four channels to different policies at once. It then walks one sequence of writes, strobes and requests, including cycles where these coincide. Each vector therefore checks the commit point of every policy against every other. Directed tests then cover reset values, field readback and a request that lands on a strobe while a request is already pending.

// File: rtl/pwm_en_sync_pkg.sv
package pwm_en_sync_pkg;
  typedef enum logic [1:0] {
    UPD_IMM    = 2'b00,
    UPD_RSVD   = 2'b01,
    UPD_LOCAL  = 2'b10,
    UPD_GLOBAL = 2'b11
  } upd_mode_e;
endpackage

// File: rtl/pwm_en_mode_reg.sv
module pwm_en_mode_reg #(
  parameter int NUM_CH = 4,
  localparam int MW = 2 * NUM_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [MW-1:0] wdata,
  output logic [MW-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mode_q <= '0;
    else if (wr) mode_q <= wdata;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> mode_q == $past(wdata)); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mode_q)); // R8
endmodule

// File: rtl/pwm_en_glb_pend.sv
module pwm_en_glb_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic cnt_zero,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= req | (pend & ~cnt_zero);
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> pend); // R5
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !req) |=> !pend); // R5
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cnt_zero) |=> pend); // R5
endmodule

// File: rtl/pwm_en_chan.sv
module pwm_en_chan
  import pwm_en_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  upd_mode_e mode,
  input  logic      wr,
  input  logic      wbit,
  input  logic      cnt_zero,
  input  logic      glb_pend,
  output logic      shadow_q,
  output logic      active_q
);
  logic next_val;
  logic commit;

  assign next_val = wr ? wbit : shadow_q;

  always_comb begin
    unique case (mode)
      UPD_LOCAL:  commit = cnt_zero;
      UPD_GLOBAL: commit = cnt_zero & glb_pend;
      default:    commit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= 1'b0;
      active_q <= 1'b0;
    end else begin
      shadow_q <= next_val;
      if (commit) active_q <= next_val;
    end
  end

  AST_IMM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == UPD_IMM || mode == UPD_RSVD) && wr) |=> active_q == $past(wbit)); // R1
  AST_LOCAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_LOCAL && !cnt_zero) |=> $stable(active_q)); // R2
  AST_SYNC_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_LOCAL && cnt_zero) |=> active_q == shadow_q); // R6
  AST_GLB_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_GLOBAL && !(cnt_zero && glb_pend)) |=> $stable(active_q)); // R3
  AST_GLB_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_GLOBAL && cnt_zero && glb_pend) |=> active_q == shadow_q); // R3
  AST_REQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> shadow_q == $past(wbit)); // R9
endmodule

// File: rtl/pwm_en_sync.sv
module pwm_en_sync
  import pwm_en_sync_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int MW = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic [NUM_CH-1:0] en_wdata,
  input  logic              mode_wr,
  input  logic [MW-1:0]     mode_wdata,
  input  logic              cnt_zero,
  input  logic              glb_req,
  output logic [NUM_CH-1:0] en_active,
  output logic [NUM_CH-1:0] en_req,
  output logic [MW-1:0]     mode_cfg,
  output logic              glb_pending
);
  logic pend_q;

  pwm_en_mode_reg #(.NUM_CH(NUM_CH)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .mode_q (mode_cfg)
  );

  pwm_en_glb_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (glb_req),
    .cnt_zero (cnt_zero),
    .pend     (pend_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    upd_mode_e ch_mode;
    assign ch_mode = upd_mode_e'(mode_cfg[2*i +: 2]);

    pwm_en_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (ch_mode),
      .wr       (en_wr),
      .wbit     (en_wdata[i]),
      .cnt_zero (cnt_zero),
      .glb_pend (pend_q),
      .shadow_q (en_req[i]),
      .active_q (en_active[i])
    );
  end

  assign glb_pending = pend_q;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (en_active == '0 && glb_pending == 1'b0 && mode_cfg == '0)); // R7
endmodule

// File: tb/test_pwm_en_sync.sv
module test_pwm_en_sync;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NV  = 13;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           en_wr;
  logic [NCH-1:0] en_wdata;
  logic           mode_wr;
  logic [2*NCH-1:0] mode_wdata;
  logic           cnt_zero;
  logic           glb_req;
  logic [NCH-1:0] en_active;
  logic [NCH-1:0] en_req;
  logic [2*NCH-1:0] mode_cfg;
  logic           glb_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_en_sync #(.NUM_CH(NCH)) i_pwm_en_sync (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .cnt_zero(cnt_zero),
    .glb_req(glb_req), .en_active(en_active), .en_req(en_req),
    .mode_cfg(mode_cfg), .glb_pending(glb_pending)
  );

  // fields: en_wr, en_wdata, mode_wr, mode_wdata, cnt_zero, glb_req, exp active, exp pending
  // policies: ch3 reserved (01), ch2 global (11), ch1 local (10), ch0 immediate (00)
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'h0, 1'b1, 8'h78, 1'b0, 1'b0, 4'h0, 1'b0},
    {1'b1, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 4'h9, 1'b0},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, 4'h9, 1'b0},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 4'hB, 1'b0},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b1, 4'hB, 1'b1},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, 4'hB, 1'b1},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 4'hF, 1'b0},
    {1'b1, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 4'h4, 1'b0},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 4'h4, 1'b1},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 4'h0, 1'b0},
    {1'b1, 4'h6, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0, 1'b0},
    {1'b1, 4'h2, 1'b0, 8'h00, 1'b0, 1'b1, 4'h0, 1'b1},
    {1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 4'h2, 1'b0}
  };
  localparam string TAG [NV] = '{
    "R8", "R4", "R2", "R2", "R5", "R3", "R3",
    "R6", "R5", "R3", "R1", "R9", "R9"
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    en_wr = 1'b0; en_wdata = '0; mode_wr = 1'b0; mode_wdata = '0;
    cnt_zero = 1'b0; glb_req = 1'b0;
  endtask

  // drive on falling edge, one rising edge, sample at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7", "active", 32'(en_active), 32'h0);
    check("R7", "pending", 32'(glb_pending), 32'h0);
    check("R7", "mode", 32'(mode_cfg), 32'h0);
    check("R7", "req", 32'(en_req), 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      {en_wr, en_wdata, mode_wr, mode_wdata, cnt_zero, glb_req} = VEC[k][20:5];
      step();
      idle_inputs();
      check(TAG[k], $sformatf("vec%0d active", k), 32'(en_active), 32'(VEC[k][4:1]));
      check(TAG[k], $sformatf("vec%0d pending", k), 32'(glb_pending), 32'(VEC[k][0]));
    end
    check("R8", "mode readback", 32'(mode_cfg), 32'h78);
    check("R9", "req readback", 32'(en_req), 32'h2);

    // R2: local channel holds across many idle cycles after a write
    en_wr = 1'b1; en_wdata = 4'h0; step(); idle_inputs();
    repeat (20) step();
    check("R2", "local hold", 32'(en_active[1]), 32'h1);
    cnt_zero = 1'b1; step(); idle_inputs();
    check("R2", "local commit", 32'(en_active[1]), 32'h0);

    // R5: request on a strobe while already pending keeps flag set and commits
    en_wr = 1'b1; en_wdata = 4'h4; step(); idle_inputs();
    glb_req = 1'b1; step(); idle_inputs();
    check("R5", "set", 32'(glb_pending), 32'h1);
    check("R3", "no commit before strobe", 32'(en_active[2]), 32'h0);
    glb_req = 1'b1; cnt_zero = 1'b1; step(); idle_inputs();
    check("R5", "req on strobe keeps", 32'(glb_pending), 32'h1);
    check("R3", "global commit", 32'(en_active[2]), 32'h1);
    cnt_zero = 1'b1; step(); idle_inputs();
    check("R5", "cleared", 32'(glb_pending), 32'h0);

    // R8: each channel follows only its own field; all immediate now except ch2
    mode_wr = 1'b1; mode_wdata = 8'h30; step(); idle_inputs();
    en_wr = 1'b1; en_wdata = 4'hB; step(); idle_inputs();
    check("R8", "field isolation", 32'(en_active), 32'hF);
    en_wr = 1'b1; en_wdata = 4'h0; step(); idle_inputs();
    check("R1", "immediate clear", 32'(en_active), 32'h4);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule